// File: doc/BRIEF.md
# Dirty-Window Flush Controller

This block writes back the dirty lines of a set-associative cache directory when a whole-cache flush is requested, and cleans single lines on request. It does not scan every set. It keeps a running window, the lowest and highest set index that have received a dirty-line mark, and a flush sweep walks only the sets inside that window, in ascending order. In each visited set it issues one writeback per dirty way, lowest way first. For every writeback the writeback port accepts, it clears that dirty bit through the directory write port in the same cycle.

The directory is read combinationally through a set-index output and a dirty-vector input. A directory array is expected to drive `dir_rd_dirty` from `dir_rd_set` in the same cycle and to apply a clear at the clock edge. Cache logic reports each newly dirtied set on the mark inputs. Single-line clean requests wait in a small request queue whose depth need not be a power of two. Each one writes back its line if the line is dirty, and returns a response pulse when it completes if its need-response flag was set.

The empty window is encoded as min greater than max. The reset value is min = SETS-1 and max = 0, so the first mark loads both bounds.

Top module: `flush_range_ctrl`

## Requirements
- R1: After reset, flush_ready and clean_ready are 1, and wb_valid, flush_done and clean_rsp are 0. The dirty window is empty.
- R2: The window lower bound is the minimum, and the upper bound the maximum, of the mark_set values received since the window was last emptied.
- R3: A sweep visits sets from the window minimum to the window maximum in ascending order, never outside it. In each set it presents one writeback for each dirty way, lowest way index first, with wb_set being the set and wb_way the way.
- R4: In the cycle a writeback is accepted (wb_valid and wb_ready both 1), dir_clr_valid is 1 with the same set and way. dir_clr_valid is 0 in every other cycle.
- R5: While wb_valid is 1 and wb_ready is 0, the next cycle presents the same wb_set and wb_way, and the sweep does not advance.
- R6: When the sweep reaches a set at or above the window maximum that has no dirty way left, flush_done is 1 in the next cycle for that cycle only. The window is then emptied, apart from marks received during the sweep.
- R7: A flush accepted while the window is empty issues no writeback and raises flush_done exactly one cycle later.
- R8: flush_ready is 0 while a sweep is in progress and while the clean queue holds any request. It is 1 otherwise.
- R9: The head clean request (set, way, need_rsp) writes back its line if that way's dirty bit is 1, and completes without a writeback if the bit is 0. clean_rsp is 1 in the cycle after completion only if need_rsp was 1.
- R10: The clean queue holds QDEPTH requests (default 3) and serves them in arrival order. clean_ready is 0 while it is full, and a request offered then is dropped.
- R11: A mark received during a sweep, at any set, is held in the window after the sweep ends, so the next flush writes that line back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_valid | input | 1 | Full-flush request |
| flush_ready | output | 1 | Flush request can be taken |
| flush_done | output | 1 | One-cycle flush completion pulse |
| clean_valid | input | 1 | Single-line clean request |
| clean_ready | output | 1 | Clean queue has room |
| clean_set | input | SW | Set of the line to clean |
| clean_way | input | WW | Way of the line to clean |
| clean_need_rsp | input | 1 | Request a completion response |
| clean_rsp | output | 1 | One-cycle clean completion response |
| mark_valid | input | 1 | A line in mark_set became dirty |
| mark_set | input | SW | Set index of the newly dirtied line |
| dir_rd_set | output | SW | Directory read set index |
| dir_rd_dirty | input | WAYS | Dirty bits of the set being read |
| dir_clr_valid | output | 1 | Clear one dirty bit |
| dir_clr_set | output | SW | Set of the bit to clear |
| dir_clr_way | output | WW | Way of the bit to clear |
| wb_valid | output | 1 | Writeback request |
| wb_ready | input | 1 | Writeback accepted |
| wb_set | output | SW | Set of the line to write back |
| wb_way | output | WW | Way of the line to write back |

## Verification
The bench flushes an empty window and expects completion one cycle later. A design that always swept would instead emit writebacks or complete late. It places dirty lines at set 0 and set SETS-1 and at scattered middle sets. A wrong bound update would skip one of those lines, and an off-by-one at the window end would loop past the maximum or miss the last set. It holds wb_ready low both mid-sweep and with a dirty clean request at the queue head, so a design that advanced during a stall would drop a line or change the presented way. It also fills the three-entry queue, and marks a line during a sweep below the set being visited, so a design that lost such marks would leave that line dirty after the next flush.

// File: rtl/flush_pkg.sv
// Shared definitions for the dirty-window flush controller.
package flush_pkg;
    // Controller activity: idle (serving clean requests) or sweeping.
    typedef enum logic {
        FL_IDLE  = 1'b0,
        FL_SWEEP = 1'b1
    } fl_state_t;
endpackage

// File: rtl/flush_req_fifo.sv
// Clean-request queue. DEPTH may be any value >= 1; the pointers wrap
// explicitly instead of relying on power-of-two overflow.
// Assumes: push while full is not passed in (the caller gates it).
module flush_req_fifo #(
    parameter int DEPTH = 3,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LASTP = PW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign dout  = mem[rd_ptr];

    // Storage write on push.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy update with explicit wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LASTP) ? '0 : wr_ptr + PW'(1);
            if (pop)  rd_ptr <= (rd_ptr == LASTP) ? '0 : rd_ptr + PW'(1);
            if (push && !pop)      count <= count + CW'(1);
            else if (pop && !push) count <= count - CW'(1);
        end
    end
endmodule

// File: rtl/flush_way_pick.sv
// Priority picker: finds the lowest-numbered set bit of a dirty vector.
// Assumes: the result index is meaningful only when any is 1.
module flush_way_pick #(
    parameter int WAYS = 4
) (
    input  logic [WAYS-1:0]                     vec,
    output logic                                any,
    output logic [(WAYS>1?$clog2(WAYS):1)-1:0]  idx
);
    localparam int WW = (WAYS > 1) ? $clog2(WAYS) : 1;

    assign any = |vec;

    // Scan from the top down so the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (vec[i]) idx = WW'(i);
        end
    end
endmodule

// File: rtl/flush_dirty_window.sv
// Dirty-set window tracker. Holds a live [min,max] window and a shadow
// window that collects marks arriving during a sweep. Empty is encoded as
// min = SETS-1, max = 0, so the first mark loads both bounds.
// Assumes: restart and commit are never asserted together.
module flush_dirty_window #(
    parameter int SETS = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mark_valid,
    input  logic [$clog2(SETS)-1:0]  mark_set,
    input  logic                     restart,
    input  logic                     commit,
    output logic [$clog2(SETS)-1:0]  win_min,
    output logic [$clog2(SETS)-1:0]  win_max,
    output logic                     win_empty
);
    localparam int SW = $clog2(SETS);
    localparam logic [SW-1:0] EMPTY_MIN = SW'(SETS - 1);
    localparam logic [SW-1:0] EMPTY_MAX = '0;

    logic [SW-1:0] sh_min, sh_max;
    logic [SW-1:0] live_min_n, live_max_n, sh_min_n, sh_max_n;
    logic [SW-1:0] base_min, base_max;

    assign win_empty = (win_min > win_max);

    // Pick the window the live copy starts from and fold in this cycle's mark.
    always_comb begin
        base_min   = commit ? sh_min : win_min;
        base_max   = commit ? sh_max : win_max;
        live_min_n = (mark_valid && mark_set < base_min) ? mark_set : base_min;
        live_max_n = (mark_valid && mark_set > base_max) ? mark_set : base_max;
    end

    // Shadow window: cleared on restart, otherwise accumulates marks.
    always_comb begin
        sh_min_n = restart ? EMPTY_MIN : sh_min;
        sh_max_n = restart ? EMPTY_MAX : sh_max;
        if (mark_valid && mark_set < sh_min_n) sh_min_n = mark_set;
        if (mark_valid && mark_set > sh_max_n) sh_max_n = mark_set;
    end

    // Window registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_min <= EMPTY_MIN;
            win_max <= EMPTY_MAX;
            sh_min  <= EMPTY_MIN;
            sh_max  <= EMPTY_MAX;
        end else begin
            win_min <= live_min_n;
            win_max <= live_max_n;
            sh_min  <= sh_min_n;
            sh_max  <= sh_max_n;
        end
    end
endmodule

// File: rtl/flush_range_ctrl.sv
// Dirty-window flush controller top. In idle it serves queued single-line
// clean requests; on a flush it sweeps the sets between the window bounds,
// writing back every dirty way and clearing its directory bit.
// Assumes: dir_rd_dirty is a combinational function of dir_rd_set, and a
// directory clear takes effect at the clock edge it is issued on.
module flush_range_ctrl #(
    parameter int SETS   = 16,
    parameter int WAYS   = 4,
    parameter int QDEPTH = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                flush_valid,
    output logic                                flush_ready,
    output logic                                flush_done,
    input  logic                                clean_valid,
    output logic                                clean_ready,
    input  logic [$clog2(SETS)-1:0]             clean_set,
    input  logic [(WAYS>1?$clog2(WAYS):1)-1:0]  clean_way,
    input  logic                                clean_need_rsp,
    output logic                                clean_rsp,
    input  logic                                mark_valid,
    input  logic [$clog2(SETS)-1:0]             mark_set,
    output logic [$clog2(SETS)-1:0]             dir_rd_set,
    input  logic [WAYS-1:0]                     dir_rd_dirty,
    output logic                                dir_clr_valid,
    output logic [$clog2(SETS)-1:0]             dir_clr_set,
    output logic [(WAYS>1?$clog2(WAYS):1)-1:0]  dir_clr_way,
    output logic                                wb_valid,
    input  logic                                wb_ready,
    output logic [$clog2(SETS)-1:0]             wb_set,
    output logic [(WAYS>1?$clog2(WAYS):1)-1:0]  wb_way
);
    import flush_pkg::*;

    localparam int SW = $clog2(SETS);
    localparam int WW = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int QW = SW + WW + 1;

    fl_state_t     state;
    logic          sweeping;
    logic [SW-1:0] idx;
    logic [SW-1:0] win_min, win_max;
    logic          win_empty;

    logic          q_empty, q_full, q_push, q_pop;
    logic [QW-1:0] q_dout;
    logic [SW-1:0] head_set;
    logic [WW-1:0] head_way;
    logic          head_rsp;

    logic          any_dirty;
    logic [WW-1:0] low_way;
    logic          head_dirty;
    logic          sweep_last, clean_done, flush_acc, wb_fire;
    logic          win_restart, win_commit;

    assign sweeping = (state == FL_SWEEP);
    assign {head_set, head_way, head_rsp} = q_dout;

    // Request queue for single-line cleans.
    assign clean_ready = !q_full;
    assign q_push      = clean_valid && !q_full;
    assign q_pop       = clean_done;

    flush_req_fifo #(.DEPTH(QDEPTH), .W(QW)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_push),
        .din   ({clean_set, clean_way, clean_need_rsp}),
        .pop   (q_pop),
        .dout  (q_dout),
        .empty (q_empty),
        .full  (q_full)
    );

    // Lowest dirty way of the set being read.
    flush_way_pick #(.WAYS(WAYS)) u_pick (
        .vec (dir_rd_dirty),
        .any (any_dirty),
        .idx (low_way)
    );

    // Dirty-set window with shadow for marks taken during a sweep.
    flush_dirty_window #(.SETS(SETS)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .mark_valid (mark_valid),
        .mark_set   (mark_set),
        .restart    (win_restart),
        .commit     (win_commit),
        .win_min    (win_min),
        .win_max    (win_max),
        .win_empty  (win_empty)
    );

    // Directory read address and per-cycle control decisions.
    always_comb begin
        dir_rd_set  = sweeping ? idx : head_set;
        head_dirty  = dir_rd_dirty[head_way];
        flush_ready = !sweeping && q_empty;
        flush_acc   = flush_valid && flush_ready;
        sweep_last  = sweeping && !any_dirty && (idx >= win_max);
        if (sweeping) begin
            wb_valid = any_dirty;
            wb_set   = idx;
            wb_way   = low_way;
        end else begin
            wb_valid = !q_empty && head_dirty;
            wb_set   = head_set;
            wb_way   = head_way;
        end
        wb_fire     = wb_valid && wb_ready;
        clean_done  = !sweeping && !q_empty && (!head_dirty || wb_ready);
        win_restart = flush_acc && !win_empty;
        win_commit  = sweep_last;
    end

    // Each accepted writeback clears its directory bit in the same cycle.
    assign dir_clr_valid = wb_fire;
    assign dir_clr_set   = wb_set;
    assign dir_clr_way   = wb_way;

    // Sweep state and set index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FL_IDLE;
            idx   <= '0;
        end else if (sweeping) begin
            if (sweep_last)      state <= FL_IDLE;
            else if (!any_dirty) idx   <= idx + SW'(1);
        end else if (win_restart) begin
            state <= FL_SWEEP;
            idx   <= win_min;
        end
    end

    // One-cycle completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_done <= 1'b0;
            clean_rsp  <= 1'b0;
        end else begin
            flush_done <= sweep_last || (flush_acc && win_empty);
            clean_rsp  <= clean_done && head_rsp;
        end
    end
endmodule

// File: rtl/flush_range_chk.sv
// Property checker for the flush controller, bound into every instance.
module flush_range_chk #(
    parameter int SETS = 16,
    parameter int WAYS = 4
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                flush_valid,
    input logic                                flush_ready,
    input logic                                flush_done,
    input logic                                wb_valid,
    input logic                                wb_ready,
    input logic [$clog2(SETS)-1:0]             wb_set,
    input logic [(WAYS>1?$clog2(WAYS):1)-1:0]  wb_way,
    input logic                                sweeping,
    input logic [$clog2(SETS)-1:0]             win_min,
    input logic [$clog2(SETS)-1:0]             win_max,
    input logic                                win_empty
);
    // R3
    sweep_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sweeping && wb_valid) |-> (wb_set >= win_min && wb_set <= win_max));

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_set) && $stable(wb_way)));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid && flush_ready && !win_empty) |=> !flush_ready);

    // R7
    empty_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid && flush_ready && win_empty) |=> flush_done);

    // R6
    done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |-> ($past(sweeping) || $past(flush_valid && flush_ready)));
endmodule

bind flush_range_ctrl flush_range_chk #(.SETS(SETS), .WAYS(WAYS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_valid (flush_valid),
    .flush_ready (flush_ready),
    .flush_done  (flush_done),
    .wb_valid    (wb_valid),
    .wb_ready    (wb_ready),
    .wb_set      (wb_set),
    .wb_way      (wb_way),
    .sweeping    (sweeping),
    .win_min     (win_min),
    .win_max     (win_max),
    .win_empty   (win_empty)
);

// File: tb/flush_range_ctrl_bench.sv
// Bench: behavioural reference model compared against the controller
// on every clock, plus scenario checks per requirement.
module flush_range_ctrl_bench;
    localparam int SETS = 16;
    localparam int WAYS = 4;
    localparam int QD   = 3;
    localparam int SW   = $clog2(SETS);
    localparam int WW   = $clog2(WAYS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          flush_valid = 0, clean_valid = 0, clean_need_rsp = 0;
    logic [SW-1:0] clean_set = 0, mark_set = 0;
    logic [WW-1:0] clean_way = 0;
    logic          mark_valid = 0, wb_ready = 1;
    logic          flush_ready, flush_done, clean_ready, clean_rsp;
    logic [SW-1:0] dir_rd_set, dir_clr_set, wb_set;
    logic [WW-1:0] dir_clr_way, wb_way;
    logic          dir_clr_valid, wb_valid;
    logic [WAYS-1:0] dir_rd_dirty;

    logic [WAYS-1:0] bdir [SETS];
    assign dir_rd_dirty = bdir[dir_rd_set];

    // Staged stimulus, applied at the falling edge.
    bit s_flush = 0, s_clean = 0, s_rsp = 0, s_mark = 0, s_ready = 1;
    int s_cset = 0, s_cway = 0, s_mset = 0, s_mway = 0;

    // Reference model state.
    int m_min = SETS - 1, m_max = 0, sh_min = SETS - 1, sh_max = 0;
    bit m_sweep = 0, m_done = 0, m_rsp = 0;
    int m_idx = 0;
    int qs[$], qw[$], qr[$];

    int checks = 0, failures = 0;
    int wb_count = 0, rsp_count = 0, done_count = 0;
    int wb_lo = 99, wb_hi = -1;
    bit obs_wbv, obs_cr;
    int obs_set;

    flush_range_ctrl #(.SETS(SETS), .WAYS(WAYS), .QDEPTH(QD)) u_flush_range_ctrl (
        .clk(clk), .rst_n(rst_n),
        .flush_valid(flush_valid), .flush_ready(flush_ready), .flush_done(flush_done),
        .clean_valid(clean_valid), .clean_ready(clean_ready), .clean_set(clean_set),
        .clean_way(clean_way), .clean_need_rsp(clean_need_rsp), .clean_rsp(clean_rsp),
        .mark_valid(mark_valid), .mark_set(mark_set),
        .dir_rd_set(dir_rd_set), .dir_rd_dirty(dir_rd_dirty),
        .dir_clr_valid(dir_clr_valid), .dir_clr_set(dir_clr_set), .dir_clr_way(dir_clr_way),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_set(wb_set), .wb_way(wb_way)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic void merge(inout int mn, inout int mx, input bit v, input int s);
        if (v) begin
            if (s < mn) mn = s;
            if (s > mx) mx = s;
        end
    endfunction

    // One clock: drive, compare with the model before the edge, update after it.
    task automatic step();
        int rs, low, e_set, e_way;
        bit any, e_wbv, last, cdone, facc, e_fr, e_cr, head_rsp;
        logic [WAYS-1:0] dv;
        @(negedge clk);
        flush_valid = s_flush; clean_valid = s_clean; clean_need_rsp = s_rsp;
        clean_set = SW'(s_cset); clean_way = WW'(s_cway);
        mark_valid = s_mark; mark_set = SW'(s_mset); wb_ready = s_ready;
        #1;
        rs = m_sweep ? m_idx : (qs.size() > 0 ? qs[0] : 0);
        dv = bdir[rs];
        any = (dv != 0);
        low = 0;
        for (int i = WAYS - 1; i >= 0; i--) if (dv[i]) low = i;
        e_wbv = 0; e_set = 0; e_way = 0; last = 0; cdone = 0; head_rsp = 0;
        if (m_sweep) begin
            e_wbv = any; e_set = m_idx; e_way = low;
            last = !any && (m_idx >= m_max);
        end else if (qs.size() > 0) begin
            e_wbv = dv[qw[0]]; e_set = qs[0]; e_way = qw[0];
            cdone = !e_wbv || s_ready;
            head_rsp = qr[0][0];
        end
        e_fr = !m_sweep && (qs.size() == 0);
        e_cr = (qs.size() < QD);
        facc = s_flush && e_fr;
        check(flush_ready == e_fr, "R8 flush_ready", int'(flush_ready), int'(e_fr));
        check(clean_ready == e_cr, "R10 clean_ready", int'(clean_ready), int'(e_cr));
        check(wb_valid == e_wbv, "R3 wb_valid", int'(wb_valid), int'(e_wbv));
        if (e_wbv) begin
            check(int'(wb_set) == e_set, "R3 wb_set", int'(wb_set), e_set);
            check(int'(wb_way) == e_way, "R3 wb_way", int'(wb_way), e_way);
        end
        check(dir_clr_valid == (e_wbv && s_ready), "R4 dir_clr_valid",
              int'(dir_clr_valid), int'(e_wbv && s_ready));
        if (e_wbv && s_ready)
            check(int'(dir_clr_set) == e_set && int'(dir_clr_way) == e_way, "R4 dir_clr target",
                  int'(dir_clr_set) * WAYS + int'(dir_clr_way), e_set * WAYS + e_way);
        check(flush_done == m_done, "R6 flush_done", int'(flush_done), int'(m_done));
        check(clean_rsp == m_rsp, "R9 clean_rsp", int'(clean_rsp), int'(m_rsp));
        obs_wbv = wb_valid; obs_set = int'(wb_set); obs_cr = clean_ready;
        if (wb_valid && wb_ready) begin
            wb_count++;
            if (int'(wb_set) < wb_lo) wb_lo = int'(wb_set);
            if (int'(wb_set) > wb_hi) wb_hi = int'(wb_set);
        end
        if (flush_done) done_count++;
        if (clean_rsp) rsp_count++;
        @(posedge clk);
        m_done = (facc && m_min > m_max) || last;
        m_rsp = cdone && head_rsp;
        if (m_sweep) begin
            if (last) begin
                m_min = sh_min; m_max = sh_max;
                m_sweep = 0;
            end else if (!any) m_idx++;
            merge(m_min, m_max, s_mark, s_mset);
            merge(sh_min, sh_max, s_mark, s_mset);
        end else begin
            if (facc && m_min <= m_max) begin
                m_sweep = 1; m_idx = m_min;
                sh_min = SETS - 1; sh_max = 0;
            end
            merge(m_min, m_max, s_mark, s_mset);
            merge(sh_min, sh_max, s_mark, s_mset);
        end
        if (cdone) begin
            void'(qs.pop_front()); void'(qw.pop_front()); void'(qr.pop_front());
        end
        if (s_clean && e_cr) begin
            qs.push_back(s_cset); qw.push_back(s_cway); qr.push_back(int'(s_rsp));
        end
        if (e_wbv && s_ready) bdir[e_set][e_way] <= 1'b0;
        if (s_mark) bdir[s_mset][s_mway] <= 1'b1;
    endtask

    task automatic mark(input int set, input int way);
        s_mark = 1; s_mset = set; s_mway = way;
        step();
        s_mark = 0;
    endtask

    task automatic flush_and_wait(input int limit);
        int d0;
        d0 = done_count;
        s_flush = 1; step(); s_flush = 0;
        for (int n = 0; n < limit && done_count == d0; n++) step();
        check(done_count == d0 + 1, "R6 flush completes", done_count - d0, 1);
    endtask

    function automatic int dirty_total();
        int t = 0;
        for (int s = 0; s < SETS; s++) t += $countones(bdir[s]);
        return t;
    endfunction

    initial begin
        int d0, w0;
        for (int s = 0; s < SETS; s++) bdir[s] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1 reset state
        check(flush_ready && clean_ready && !wb_valid && !flush_done && !clean_rsp,
              "R1 reset outputs", {flush_ready, clean_ready, wb_valid, flush_done, clean_rsp}, 5'b11000);

        // R7 flush with empty window
        d0 = done_count; w0 = wb_count;
        s_flush = 1; step(); s_flush = 0;
        step();
        check(done_count == d0 + 1, "R7 empty flush done next cycle", done_count - d0, 1);
        check(wb_count == w0, "R7 no writebacks", wb_count - w0, 0);

        // R2 R3 R4 bounded sweep over scattered sets
        mark(5, 1); mark(9, 0); mark(7, 3); mark(9, 2);
        w0 = wb_count; wb_lo = 99; wb_hi = -1;
        flush_and_wait(60);
        check(wb_count == w0 + 4, "R3 writeback count", wb_count - w0, 4);
        check(wb_lo == 5, "R2 lowest swept set", wb_lo, 5);
        check(wb_hi == 9, "R2 highest swept set", wb_hi, 9);
        check(dirty_total() == 0, "R4 directory clean after sweep", dirty_total(), 0);

        // R6 window emptied: next flush is an empty one
        d0 = done_count;
        s_flush = 1; step(); s_flush = 0; step();
        check(done_count == d0 + 1, "R6 window reset after sweep", done_count - d0, 1);

        // R5 stall mid-sweep
        mark(2, 1); mark(3, 0);
        s_ready = 0;
        s_flush = 1; step(); s_flush = 0;
        repeat (3) step();
        check(obs_wbv && obs_set == 2, "R5 stalled writeback held", obs_set, 2);
        s_ready = 1;
        w0 = wb_count;
        for (int n = 0; n < 40 && dirty_total() != 0; n++) step();
        repeat (3) step();
        check(wb_count == w0 + 2, "R5 stall loses no line", wb_count - w0, 2);

        // R9 R10 clean requests with a full queue
        mark(4, 2);
        s_ready = 0; w0 = wb_count; d0 = rsp_count;
        s_clean = 1; s_cset = 4; s_cway = 2; s_rsp = 1; step();
        step();
        s_cset = 6; s_cway = 1; s_rsp = 0; step();
        s_cset = 8; s_cway = 0; s_rsp = 1; step();
        check(!obs_cr, "R10 clean_ready low when full", int'(obs_cr), 0);
        s_clean = 0; s_ready = 1;
        repeat (6) step();
        check(wb_count == w0 + 1, "R9 only dirty line written back", wb_count - w0, 1);
        check(rsp_count == d0 + 2, "R9 responses only with need_rsp", rsp_count - d0, 2);

        // R11 mark during sweep below the visited set is kept
        mark(10, 0);
        s_flush = 1; step(); s_flush = 0;
        mark(1, 0);
        for (int n = 0; n < 20 && !m_done; n++) step();
        step();
        w0 = wb_count; wb_lo = 99;
        flush_and_wait(40);
        check(wb_count == w0 + 1 && wb_lo == 1, "R11 mark during sweep retained", wb_lo, 1);

        // R2 R3 boundary sets 0 and SETS-1
        mark(0, 3); mark(SETS - 1, 0);
        w0 = wb_count; wb_lo = 99; wb_hi = -1;
        flush_and_wait(60);
        check(wb_count == w0 + 2, "R3 edge sets written back", wb_count - w0, 2);
        check(wb_lo == 0 && wb_hi == SETS - 1, "R2 edge bounds", wb_hi, SETS - 1);
        check(dirty_total() == 0, "R4 directory clean at end", dirty_total(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog.
    initial begin
        #2000000;
        checks++; failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule